// File: doc/BRIEF.md
# Path Chromosome Variation Unit

This unit produces modified candidate flight paths for an evolutionary path planner. A candidate (a chromosome) carries four intermediate 3-D waypoints followed by a cost field. Two fixed endpoints, the departure point and the arrival point, come in on their own ports. The unit uses them as neighbours and never changes them. A 4-bit operator code picks the work to do. The code either recombines two parent paths by crossover, or applies one of four mutation kinds to the first parent: swap, delete (move to the neighbour midpoint), global perturb and local perturb.

All randomness comes in on ports: the operator code and a 32-bit random word. The random number source stays outside the block, and a bench can drive every choice directly. A one-cycle start pulse loads the operands. After a fixed, parameterised number of cycles the unit raises `done` for one cycle, with both children on its outputs. Both children keep their values until the next completion. Every child has its cost field set to all ones, which marks it as not yet scored.

Top module: `path_variation_unit`

## Requirements
- R1: While reset is asserted and after its release, `done` is 0 and both child outputs are all zeros until the first completion.
- R2: A start pulse is accepted when the unit is idle. Exactly LATENCY (default 4, at least 2) rising edges after the accepting edge, `done` is 1 for a single cycle. The children then hold their values until the next completion.
- R3: A start pulse that arrives while a job is running is ignored. The running job's result is unchanged, and no extra completion follows.
- R4: The operator code maps as follows: values 0 to 11 select crossover, 12 swap, 13 delete, 14 global perturb, 15 local perturb. A uniform code therefore gives three quarters crossover and one sixteenth for each mutation kind.
- R5: Chromosome layout: waypoint k (k = 0..3, where 0 is next to the departure point) sits in bits [27k+26:27k]. Within each 27-bit waypoint, X is bits [8:0], Y is bits [17:9] and Z is bits [26:18]. The cost is bits [139:108]. An endpoint port uses the same 27-bit waypoint layout.
- R6: Crossover takes the split point from random bits [2:0], and any value above 4 counts as 4. Waypoints with index below the split stay with their own parent, and the rest are exchanged. A split of 0 exchanges the whole path, and a split of 4 leaves both parents as they were.
- R7: Swap exchanges the waypoints at indices random[1:0] and random[3:2] of the first parent. Equal indices leave the path unchanged.
- R8: Delete moves the waypoint at index random[31:30]. Each coordinate becomes floor((previous + next) / 2). The previous neighbour of waypoint 0 is the departure point, and the next neighbour of waypoint 3 is the arrival point.
- R9: Global perturb replaces the waypoint at index random[31:30] with X = random[8:0], Y = random[17:9] and Z = random[26:18].
- R10: Local perturb adds a signed 4-bit offset to each coordinate of the waypoint at index random[31:30]. The offsets are random[3:0] for X, random[7:4] for Y and random[11:8] for Z. Results are clamped to the range 0..511.
- R11: Under every mutation kind, the second child equals the second parent's waypoints. The waypoints of the first child that the operator does not target equal the first parent's.
- R12: The cost field of both children is all ones after every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; taken only when idle |
| op_code | input | 4 | Operator selector |
| rnd_word | input | 32 | Random word supplying split, indices and new values |
| wp_start | input | 27 | Departure waypoint (fixed endpoint) |
| wp_end | input | 27 | Arrival waypoint (fixed endpoint) |
| parent_a | input | 140 | First parent chromosome |
| parent_b | input | 140 | Second parent chromosome |
| done | output | 1 | One-cycle completion pulse |
| child_a | output | 140 | First child chromosome |
| child_b | output | 140 | Second child chromosome |

## Verification
Two functions can fall in the same cycle: the completion of a running job and the arrival of a fresh start pulse. A start that lands while the countdown is still running must be dropped. A start in the completion cycle itself finds the unit busy and must likewise have no effect. The bench provokes this by issuing a second start, carrying different operands, one edge after the first. It then requires that the completion comes at the first job's edge with the first job's children, and that no second `done` appears during the following cycles. The operator paths are swept near-exhaustively (all 16 codes, every split value, every index pair, every mutation target, and offsets at both clamp limits), and every child is compared with an arithmetic model in the bench.

// File: rtl/pvu_pkg.sv
`timescale 1ns/1ps
package pvu_pkg;
  localparam int CW    = 9;
  localparam int AXES  = 3;
  localparam int NWP   = 4;
  localparam int WPW   = CW * AXES;
  localparam int WPSW  = NWP * WPW;
  localparam int COSTW = 32;
  localparam int CHW   = WPSW + COSTW;
  localparam int OFSW  = 4;
  localparam int RNDW  = 32;
  localparam int OPW   = 4;
  localparam int IDXW  = $clog2(NWP);
  localparam int SPLW  = $clog2(NWP + 1);

  typedef logic [CW-1:0]  coord_t;
  typedef logic [WPW-1:0] wp_t;

  typedef enum logic [2:0] {
    OP_XOVER, OP_SWAP, OP_DELETE, OP_GLOBAL, OP_LOCAL
  } op_kind_e;

  function automatic op_kind_e decode_op(input logic [OPW-1:0] code);
    case (code)
      4'd12:   return OP_SWAP;
      4'd13:   return OP_DELETE;
      4'd14:   return OP_GLOBAL;
      4'd15:   return OP_LOCAL;
      default: return OP_XOVER;
    endcase
  endfunction

  // floor of the mean of two coordinates
  function automatic coord_t mid_coord(input coord_t p, input coord_t n);
    logic [CW:0] sum;
    sum = {1'b0, p} + {1'b0, n};
    return sum[CW:1];
  endfunction

  // signed offset added with clamping to the coordinate range
  function automatic coord_t nudge_coord(input coord_t c, input logic [OFSW-1:0] off);
    logic signed [CW+1:0] sum;
    sum = $signed({2'b00, c}) + $signed({{(CW+2-OFSW){off[OFSW-1]}}, off});
    if (sum < 0)
      return '0;
    else if (sum > $signed({2'b00, {CW{1'b1}}}))
      return '1;
    else
      return sum[CW-1:0];
  endfunction
endpackage

// File: rtl/pvu_timer.sv
`timescale 1ns/1ps
module pvu_timer #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic finish
);
  localparam int CNTW = $clog2(LATENCY + 1);

  logic [CNTW-1:0] cnt;

  assign accept = start & ~busy;
  assign finish = busy & (cnt == CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= CNTW'(LATENCY);
    end else if (finish) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt - CNTW'(1);
    end
  end

  // R2: the countdown stays inside its window while a job runs
  p_cnt_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0) && (cnt <= CNTW'(LATENCY)));

  // R3: a start seen while busy does not reload the countdown
  p_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> (cnt == $past(cnt) - CNTW'(1)));
endmodule

// File: rtl/pvu_crossover.sv
`timescale 1ns/1ps
module pvu_crossover
  import pvu_pkg::*;
(
  input  logic [WPSW-1:0] pa,
  input  logic [WPSW-1:0] pb,
  input  logic [SPLW-1:0] split_raw,
  output logic [WPSW-1:0] xa,
  output logic [WPSW-1:0] xb
);
  logic [SPLW-1:0] split_eff;

  assign split_eff = (split_raw > SPLW'(NWP)) ? SPLW'(NWP) : split_raw;

  for (genvar i = 0; i < NWP; i++) begin : g_wp
    logic keep;
    assign keep = (SPLW'(i) < split_eff);
    assign xa[i*WPW +: WPW] = keep ? pa[i*WPW +: WPW] : pb[i*WPW +: WPW];
    assign xb[i*WPW +: WPW] = keep ? pb[i*WPW +: WPW] : pa[i*WPW +: WPW];
  end
endmodule

// File: rtl/pvu_mutator.sv
`timescale 1ns/1ps
module pvu_mutator
  import pvu_pkg::*;
(
  input  logic [WPSW-1:0] pa,
  input  wp_t             wp_start,
  input  wp_t             wp_end,
  input  op_kind_e        kind,
  input  logic [RNDW-1:0] rnd,
  output logic [WPSW-1:0] ma
);
  logic [IDXW-1:0] tgt, sw1, sw2;
  wp_t             fresh;
  logic            unused_rnd;

  assign tgt        = rnd[RNDW-1 -: IDXW];
  assign sw1        = rnd[IDXW-1:0];
  assign sw2        = rnd[2*IDXW-1:IDXW];
  assign fresh      = rnd[WPW-1:0];
  assign unused_rnd = ^rnd[RNDW-IDXW-1:WPW];

  for (genvar i = 0; i < NWP; i++) begin : g_wp
    wp_t own, prev, next, mid, nudged, swapped, hit;
    logic is_tgt;

    assign own    = pa[i*WPW +: WPW];
    assign is_tgt = (tgt == IDXW'(i));

    if (i == 0) begin : g_first
      assign prev = wp_start;
    end else begin : g_prev
      assign prev = pa[(i-1)*WPW +: WPW];
    end
    if (i == NWP-1) begin : g_last
      assign next = wp_end;
    end else begin : g_next
      assign next = pa[(i+1)*WPW +: WPW];
    end

    for (genvar a = 0; a < AXES; a++) begin : g_ax
      assign mid[a*CW +: CW]    = mid_coord(prev[a*CW +: CW], next[a*CW +: CW]);
      assign nudged[a*CW +: CW] = nudge_coord(own[a*CW +: CW], rnd[a*OFSW +: OFSW]);
    end

    assign swapped = (sw1 == IDXW'(i)) ? pa[sw2*WPW +: WPW] :
                     (sw2 == IDXW'(i)) ? pa[sw1*WPW +: WPW] : own;

    always_comb begin
      case (kind)
        OP_SWAP:   hit = swapped;
        OP_DELETE: hit = is_tgt ? mid    : own;
        OP_GLOBAL: hit = is_tgt ? fresh  : own;
        OP_LOCAL:  hit = is_tgt ? nudged : own;
        default:   hit = own;
      endcase
    end
    assign ma[i*WPW +: WPW] = hit;
  end
endmodule

// File: rtl/path_variation_unit.sv
`timescale 1ns/1ps
module path_variation_unit
  import pvu_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPW-1:0]   op_code,
  input  logic [RNDW-1:0]  rnd_word,
  input  logic [WPW-1:0]   wp_start,
  input  logic [WPW-1:0]   wp_end,
  input  logic [CHW-1:0]   parent_a,
  input  logic [CHW-1:0]   parent_b,
  output logic             done,
  output logic [CHW-1:0]   child_a,
  output logic [CHW-1:0]   child_b
);
  localparam int AGEW = $clog2(LATENCY + 2);

  logic            busy, accept, finish;
  logic [OPW-1:0]  op_q;
  logic [RNDW-1:0] rnd_q;
  logic [WPSW-1:0] pa_q, pb_q;
  wp_t             s_q, e_q;
  op_kind_e        kind_q;
  logic [WPSW-1:0] xa, xb, ma, res_a, res_b;
  logic            unused_cost;

  assign unused_cost = ^{parent_a[CHW-1:WPSW], parent_b[CHW-1:WPSW]};

  pvu_timer #(.LATENCY(LATENCY)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .accept(accept), .finish(finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      rnd_q <= '0;
      pa_q  <= '0;
      pb_q  <= '0;
      s_q   <= '0;
      e_q   <= '0;
    end else if (accept) begin
      op_q  <= op_code;
      rnd_q <= rnd_word;
      pa_q  <= parent_a[WPSW-1:0];
      pb_q  <= parent_b[WPSW-1:0];
      s_q   <= wp_start;
      e_q   <= wp_end;
    end
  end

  assign kind_q = decode_op(op_q);

  pvu_crossover u_xover (
    .pa(pa_q), .pb(pb_q), .split_raw(rnd_q[SPLW-1:0]), .xa(xa), .xb(xb)
  );

  pvu_mutator u_mut (
    .pa(pa_q), .wp_start(s_q), .wp_end(e_q), .kind(kind_q), .rnd(rnd_q), .ma(ma)
  );

  assign res_a = (kind_q == OP_XOVER) ? xa : ma;
  assign res_b = (kind_q == OP_XOVER) ? xb : pb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      child_a <= '0;
      child_b <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        child_a <= {{COSTW{1'b1}}, res_a};
        child_b <= {{COSTW{1'b1}}, res_b};
      end
    end
  end

  // checker: cycles since the accepting edge
  logic [AGEW-1:0] chk_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_age <= '0;
    else if (accept) chk_age <= AGEW'(1);
    else if (busy)   chk_age <= chk_age + AGEW'(1);
  end

  p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_age == AGEW'(LATENCY + 1)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_operands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(rnd_q) && $stable(op_q) && $stable(pa_q) && $stable(pb_q)));

  p_cost_mark_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (&child_a[CHW-1:WPSW]) && (&child_b[CHW-1:WPSW]));

  for (genvar i = 0; i < NWP; i++) begin : g_chk
    p_xover_pairs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && kind_q == OP_XOVER) |->
        ((xa[i*WPW +: WPW] == pa_q[i*WPW +: WPW] && xb[i*WPW +: WPW] == pb_q[i*WPW +: WPW]) ||
         (xa[i*WPW +: WPW] == pb_q[i*WPW +: WPW] && xb[i*WPW +: WPW] == pa_q[i*WPW +: WPW])));

    p_mut_untouched_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && (kind_q == OP_DELETE || kind_q == OP_GLOBAL || kind_q == OP_LOCAL) &&
       rnd_q[RNDW-1 -: IDXW] != IDXW'(i)) |->
        (ma[i*WPW +: WPW] == pa_q[i*WPW +: WPW]));
  end
endmodule

// File: tb/tb_path_variation_unit.sv
`timescale 1ns/1ps
module tb_path_variation_unit;
  localparam int LAT = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   op_code = '0;
  logic [31:0]  rnd_word = '0;
  logic [26:0]  wp_start = '0, wp_end = '0;
  logic [139:0] parent_a = '0, parent_b = '0;
  logic         done;
  logic [139:0] child_a, child_b;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  path_variation_unit #(.LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .rnd_word(rnd_word),
    .wp_start(wp_start), .wp_end(wp_end), .parent_a(parent_a), .parent_b(parent_b),
    .done(done), .child_a(child_a), .child_b(child_b)
  );

  task automatic chk(input string tag, input string what, input logic [139:0] act,
                     input logic [139:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int gc(input logic [139:0] c, input int w, input int x);
    return int'(c[w*27 + x*9 +: 9]);
  endfunction

  function automatic logic [139:0] rand_path();
    logic [139:0] p;
    for (int k = 0; k < 5; k++) p[k*28 +: 28] = 28'($urandom);
    return p;
  endfunction

  function automatic logic [139:0] flat_path(input int v);
    logic [139:0] p;
    p[139:108] = $urandom;
    for (int w = 0; w < 4; w++)
      for (int x = 0; x < 3; x++) p[w*27 + x*9 +: 9] = 9'(v);
    return p;
  endfunction

  // arithmetic reference for both children
  task automatic model(input logic [3:0] op, input logic [31:0] r, input logic [139:0] a,
                       input logic [139:0] b, input logic [26:0] s, input logic [26:0] e,
                       output logic [139:0] ea, output logic [139:0] eb);
    int kind, t, sp, i, j, p, n, o, v;
    kind = (op < 12) ? 0 : int'(op) - 11;
    ea = {32'hFFFF_FFFF, a[107:0]};
    eb = {32'hFFFF_FFFF, b[107:0]};
    t  = int'(r[31:30]);
    case (kind)
      0: begin
        sp = int'(r[2:0]);
        if (sp > 4) sp = 4;
        for (int w = sp; w < 4; w++) begin
          ea[w*27 +: 27] = b[w*27 +: 27];
          eb[w*27 +: 27] = a[w*27 +: 27];
        end
      end
      1: begin
        i = int'(r[1:0]); j = int'(r[3:2]);
        ea[i*27 +: 27] = a[j*27 +: 27];
        ea[j*27 +: 27] = a[i*27 +: 27];
      end
      2: for (int x = 0; x < 3; x++) begin
        p = (t == 0) ? int'(s[x*9 +: 9]) : gc(a, t-1, x);
        n = (t == 3) ? int'(e[x*9 +: 9]) : gc(a, t+1, x);
        ea[t*27 + x*9 +: 9] = 9'((p + n) / 2);
      end
      3: for (int x = 0; x < 3; x++) ea[t*27 + x*9 +: 9] = r[x*9 +: 9];
      default: for (int x = 0; x < 3; x++) begin
        o = int'(r[x*4 +: 4]);
        if (o >= 8) o = o - 16;
        v = gc(a, t, x) + o;
        if (v < 0) v = 0;
        if (v > 511) v = 511;
        ea[t*27 + x*9 +: 9] = 9'(v);
      end
    endcase
  endtask

  task automatic run(input logic [3:0] op, input logic [31:0] r, input logic [139:0] a,
                     input logic [139:0] b, input logic [26:0] s, input logic [26:0] e,
                     input string tag);
    logic [139:0] ea, eb, held_a;
    string tag_b;
    model(op, r, a, b, s, e, ea, eb);
    tag_b = (op < 12) ? tag : "R11";
    @(negedge clk);
    op_code = op; rnd_word = r; parent_a = a; parent_b = b; wp_start = s; wp_end = e;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    chk("R2", "done early", {139'b0, done}, 140'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R2", "done on time", {139'b0, done}, 140'd1);
    chk(tag, "child_a", child_a, ea);
    chk(tag_b, "child_b", child_b, eb);
    chk("R12", "cost marks", {108'b0, child_a[139:108] & child_b[139:108]},
        {108'b0, 32'hFFFF_FFFF});
    held_a = child_a;
    @(negedge clk);
    chk("R2", "done single", {139'b0, done}, 140'd0);
    chk("R2", "child held", child_a, held_a);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [139:0] a, b, ea, eb, a2;
    logic [26:0]  s, e;
    logic [31:0]  r;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "done in reset", {139'b0, done}, 140'd0);
    chk("R1", "child_a in reset", child_a, '0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "child_b after reset", child_b, '0);
    chk("R1", "done after reset", {139'b0, done}, 140'd0);

    s = 27'($urandom); e = 27'($urandom);

    // R4: every operator code
    for (int op = 0; op < 16; op++) begin
      a = rand_path(); b = rand_path();
      r = {2'd1, 30'($urandom)};
      r[2:0] = 3'd2;
      r[3:2] = 2'd3;
      run(4'(op), r, a, b, s, e, "R4");
    end

    // R6: every split value, including clamp of 5..7
    a = rand_path(); b = rand_path();
    for (int sp = 0; sp < 8; sp++) begin
      r = $urandom;
      r[2:0] = 3'(sp);
      run(4'(sp), r, a, b, s, e, "R6");
    end

    // R7: every index pair
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        a = rand_path(); b = rand_path();
        r = $urandom;
        r[3:0] = {2'(j), 2'(i)};
        run(4'd12, r, a, b, s, e, "R7");
      end

    // R8: every target, random and at the top of the range
    for (int t = 0; t < 4; t++) begin
      a = rand_path(); b = rand_path();
      r = {2'(t), 30'($urandom)};
      run(4'd13, r, a, b, 27'($urandom), 27'($urandom), "R8");
      run(4'd13, r, flat_path(511), b, '1, '1, "R8");
    end

    // R9 and R5: fresh values land in the stated fields
    for (int t = 0; t < 4; t++) begin
      a = rand_path(); b = rand_path();
      r = {2'(t), 30'($urandom)};
      run(4'd14, r, a, b, s, e, "R9");
      chk("R5", "X field", {131'b0, child_a[t*27 +: 9]}, {131'b0, r[8:0]});
      chk("R5", "Y field", {131'b0, child_a[t*27 + 9 +: 9]}, {131'b0, r[17:9]});
      chk("R5", "Z field", {131'b0, child_a[t*27 + 18 +: 9]}, {131'b0, r[26:18]});
    end

    // R10: offsets at both clamp limits and in the open range
    for (int t = 0; t < 4; t++) begin
      b = rand_path();
      r = {2'(t), 18'($urandom), 12'h888};
      run(4'd15, r, flat_path(3), b, s, e, "R10");
      r = {2'(t), 18'($urandom), 12'h777};
      run(4'd15, r, flat_path(508), b, s, e, "R10");
      r = {2'(t), 30'($urandom)};
      run(4'd15, r, rand_path(), b, s, e, "R10");
    end

    // R3: a second start while busy is ignored
    a = rand_path(); b = rand_path();
    r = {2'd2, 30'($urandom)};
    model(4'd13, r, a, b, s, e, ea, eb);
    @(negedge clk);
    op_code = 4'd13; rnd_word = r; parent_a = a; parent_b = b; wp_start = s; wp_end = e;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    a2 = rand_path();
    op_code = 4'd14; rnd_word = ~r; parent_a = a2;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (LAT - 2) @(posedge clk);
    @(negedge clk);
    chk("R3", "no early done", {139'b0, done}, 140'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R3", "first job done", {139'b0, done}, 140'd1);
    chk("R3", "first job child_a", child_a, ea);
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      chk("R3", "no second done", {139'b0, done}, 140'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule